// File: doc/BRIEF.md
# Multiplexed-Bus to Static Memory Bridge

This block sits between a display controller that expects dynamic memory and a static memory with a flat address input. The controller puts three things on one shared 8-bit bus, one after another. First comes the row part of the address, then the column part, then write data when the access is a write. It frames these phases with active-low row, column and write strobes. The bridge takes each address part on the falling edge of its strobe. It joins the two parts into a 14-bit address, drives the static memory's chip select, output enable and write enable, and sends the memory's read data back on the controller's separate read bus.

The controller numbers its data pins with bit 0 as the most significant bit. The bridge reverses the bit order in both directions, so the memory sees ordinary numbering. The memory write pulse is timed by the clock: it lasts a fixed number of clock periods, however long the controller keeps its write strobe low. All strobe inputs are sampled on `clk`, and a falling edge is detected as "high at the previous edge, low now".

Top module: `muxbus_sram_bridge`

## Requirements
- R1: Pin `busAd[i]` carries logical bit `7-i`. Address capture and `memWrData` use logical numbering, so a logical value V appears on the pins as V with its bit order reversed.
- R2: At a clock edge where `rasN` is low and was high at the previous edge, logical bus bits 7..0 are stored and appear on `memAddr[7:0]` after that edge.
- R3: At a clock edge where `casN` is low and was high at the previous edge, logical bus bits 5..0 are stored and appear on `memAddr[13:8]`. Later bus changes while `casN` stays low leave `memAddr` unchanged.
- R4: `memCsN` is low from the clock edge that captures the column until `casN` goes high. After reset, `memCsN`, `memOeN` and `memWeN` are high and `memAddr` is 0.
- R5: `memOeN` is low only while chip select is active and `rwN` is high.
- R6: `memWeN` is low only while chip select is active and both `casN` and `rwN` are low. A low `rwN` without a column access has no effect.
- R7: The write pulse starts at the first clock edge that sees `casN` and `rwN` both low. It lasts exactly `WE_CYCLES` clock periods (default 2), even if `rwN` stays low longer.
- R8: The stored row part stays on `memAddr[7:0]` across any number of column accesses, until the next falling edge of `rasN`.
- R9: `memWrData` is the shared bus with its bit order remapped as in R1, so write data is taken during the data phase.
- R10: `ctrlRdData[i]` equals `memRdData[7-i]`, without any clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAd | input | 8 | Shared address/data bus, pin bit 0 is MSB |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| rwN | input | 1 | Write strobe, active low |
| ctrlRdData | output | 8 | Read data to controller, pin bit 0 is MSB |
| memAddr | output | 14 | Flat static memory address |
| memCsN | output | 1 | Memory chip select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memWrData | output | 8 | Write data to memory, normal numbering |
| memRdData | input | 8 | Read data from memory, normal numbering |

## Verification
A vector table runs reads and writes with rows and columns chosen to show up mistakes. Single-bit rows such as 0x01 and 0x80 catch a missing or doubled bit reversal. Columns with the top two bits set catch a wrong column mask. Uneven data bytes tell the write path apart from the read path. Directed sequences then keep the row strobe low across two column accesses, which separates a held row from a re-captured one. They hold the write strobe well past the pulse length, which separates a clock-timed pulse from one that follows the strobe. They also drop the write strobe with no column access and change the bus during the data phase, which shows that neither one disturbs the outputs.

// File: rtl/membr_pkg.sv
package membr_pkg;

  // Capture strobes passed from control to datapath
  typedef struct packed {
    logic captureRow;
    logic captureCol;
  } membr_strobe_t;

endpackage

// File: rtl/membr_ctrl.sv
module membr_ctrl
  import membr_pkg::*;
#(
  parameter int WE_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rasN,
  input  logic          casN,
  input  logic          rwN,
  output membr_strobe_t strobe,
  output logic          memCsN,
  output logic          memOeN,
  output logic          memWeN
);

  localparam int CNT_W = $clog2(WE_CYCLES + 1);
  localparam int RUN_W = $clog2(WE_CYCLES + 2);

  logic             rasQ;
  logic             casQ;
  logic             bothLowQ;
  logic [CNT_W-1:0] pulseCnt;
  logic             bothLow;
  logic             csActive;

  assign bothLow  = ~casN & ~rwN;
  assign csActive = ~casN & ~casQ;

  always_comb begin
    strobe.captureRow = rasQ & ~rasN;
    strobe.captureCol = casQ & ~casN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rasQ     <= 1'b1;
      casQ     <= 1'b1;
      bothLowQ <= 1'b0;
      pulseCnt <= '0;
    end else begin
      rasQ     <= rasN;
      casQ     <= casN;
      bothLowQ <= bothLow;
      if (!bothLow) begin
        pulseCnt <= '0;
      end else if (!bothLowQ) begin
        pulseCnt <= CNT_W'(WE_CYCLES);
      end else if (pulseCnt != '0) begin
        pulseCnt <= pulseCnt - 1'b1;
      end
    end
  end

  assign memCsN = ~csActive;
  assign memOeN = ~(csActive & rwN);
  assign memWeN = ~(csActive & bothLow & (pulseCnt != '0));

  // Checker counter: consecutive clock periods with write enable low
  logic [RUN_W-1:0] weRun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      weRun <= '0;
    end else if (memWeN) begin
      weRun <= '0;
    end else if (weRun != '1) begin
      weRun <= weRun + 1'b1;
    end
  end

  a_r5_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !memOeN |-> (rwN && !memCsN));

  a_r6_we_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    !memWeN |-> (!casN && !rwN && !memCsN));

  a_r7_we_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    weRun <= RUN_W'(WE_CYCLES));

  a_r4_cs_follows_cas: assert property (@(posedge clk) disable iff (!rst_n)
    casN |-> memCsN);

endmodule

// File: rtl/membr_datapath.sv
module membr_datapath
  import membr_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  membr_strobe_t     strobe,
  input  logic [BUS_W-1:0]  busAd,
  input  logic [BUS_W-1:0]  memRdData,
  output logic [BUS_W-1:0]  ctrlRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BUS_W-1:0]  memWrData
);

  logic [BUS_W-1:0] logicalBus;
  logic [ROW_W-1:0] rowReg;
  logic [COL_W-1:0] colReg;

  // Pin numbering is MSB-first; swap order in both directions
  for (genvar i = 0; i < BUS_W; i++) begin : g_swap
    assign logicalBus[i] = busAd[BUS_W-1-i];
    assign ctrlRdData[i] = memRdData[BUS_W-1-i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowReg <= '0;
      colReg <= '0;
    end else begin
      if (strobe.captureRow) rowReg <= logicalBus[ROW_W-1:0];
      if (strobe.captureCol) colReg <= logicalBus[COL_W-1:0];
    end
  end

  assign memAddr   = {colReg, rowReg};
  assign memWrData = logicalBus;

  a_r2_row_capture: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.captureRow |=> (memAddr[ROW_W-1:0] == $past(logicalBus[ROW_W-1:0])));

  a_r8_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.captureRow |=> $stable(memAddr[ROW_W-1:0]));

  a_r3_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.captureCol |=> $stable(memAddr[ADDR_W-1:ROW_W]));

endmodule

// File: rtl/muxbus_sram_bridge.sv
module muxbus_sram_bridge
  import membr_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int WE_CYCLES = 2,
  localparam int ADDR_W   = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  busAd,
  input  logic              rasN,
  input  logic              casN,
  input  logic              rwN,
  output logic [BUS_W-1:0]  ctrlRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [BUS_W-1:0]  memWrData,
  input  logic [BUS_W-1:0]  memRdData
);

  membr_strobe_t strobe;

  membr_ctrl #(
    .WE_CYCLES(WE_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rasN   (rasN),
    .casN   (casN),
    .rwN    (rwN),
    .strobe (strobe),
    .memCsN (memCsN),
    .memOeN (memOeN),
    .memWeN (memWeN)
  );

  membr_datapath #(
    .BUS_W(BUS_W),
    .ROW_W(ROW_W),
    .COL_W(COL_W)
  ) u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .busAd      (busAd),
    .memRdData  (memRdData),
    .ctrlRdData (ctrlRdData),
    .memAddr    (memAddr),
    .memWrData  (memWrData)
  );

endmodule

// File: tb/muxbus_sram_bridge_bench.sv
module muxbus_sram_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 6;

  // Vector table: row, column, data, write flag
  localparam logic [7:0] ROWS [NVEC] = '{8'h01, 8'h80, 8'hA5, 8'h3C, 8'hFF, 8'h00};
  localparam logic [7:0] COLS [NVEC] = '{8'h00, 8'hFF, 8'h12, 8'hC7, 8'h3F, 8'h21};
  localparam logic [7:0] DATS [NVEC] = '{8'h01, 8'h80, 8'h6B, 8'hD2, 8'h0F, 8'hE4};
  localparam bit         WRS  [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAd = '0;
  logic        rasN = 1'b1;
  logic        casN = 1'b1;
  logic        rwN = 1'b1;
  logic [7:0]  ctrlRdData;
  logic [13:0] memAddr;
  logic        memCsN;
  logic        memOeN;
  logic        memWeN;
  logic [7:0]  memWrData;
  logic [7:0]  memRdData = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxbus_sram_bridge u_muxbus_sram_bridge (
    .clk        (clk),
    .rst_n      (rst_n),
    .busAd      (busAd),
    .rasN       (rasN),
    .casN       (casN),
    .rwN        (rwN),
    .ctrlRdData (ctrlRdData),
    .memAddr    (memAddr),
    .memCsN     (memCsN),
    .memOeN     (memOeN),
    .memWeN     (memWeN),
    .memWrData  (memWrData),
    .memRdData  (memRdData)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic startRow(input logic [7:0] rowL);
    @(negedge clk);
    busAd = rev8(rowL);
    rasN  = 1'b0;
  endtask

  task automatic colAccess(input logic [7:0] rowL, input logic [7:0] colL,
                           input logic [7:0] datL, input bit wr, input string addrReq);
    logic [13:0] expA;
    expA = {colL[5:0], rowL};
    @(negedge clk);
    busAd = rev8(colL);
    casN  = 1'b0;
    @(negedge clk);
    chk(addrReq, 32'(memAddr), 32'(expA));
    chk("R4 cs active after column capture", 32'(memCsN), 32'd0);
    if (wr) begin
      busAd = rev8(datL);
      rwN   = 1'b0;
      @(negedge clk);
      chk("R7 write pulse first period", 32'(memWeN), 32'd0);
      chk("R9 write data remapped", 32'(memWrData), 32'(datL));
      chk("R3 address unchanged in data phase", 32'(memAddr), 32'(expA));
      chk("R5 oe off for write", 32'(memOeN), 32'd1);
      @(negedge clk);
      chk("R7 write pulse second period", 32'(memWeN), 32'd0);
      @(negedge clk);
      chk("R7 pulse ends while rwN held", 32'(memWeN), 32'd1);
    end else begin
      memRdData = datL;
      #1;
      chk("R10 read data reversed", 32'(ctrlRdData), 32'(rev8(datL)));
      chk("R5 oe on for read", 32'(memOeN), 32'd0);
      chk("R6 no write on read", 32'(memWeN), 32'd1);
      @(negedge clk);
    end
    casN = 1'b1;
    rwN  = 1'b1;
    @(negedge clk);
    chk("R4 cs released with casN", 32'(memCsN), 32'd1);
    chk("R6 we released", 32'(memWeN), 32'd1);
  endtask

  task automatic endRow();
    rasN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset cs", 32'(memCsN), 32'd1);
    chk("R4 reset oe", 32'(memOeN), 32'd1);
    chk("R4 reset we", 32'(memWeN), 32'd1);
    chk("R4 reset address", 32'(memAddr), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R5 R7 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      startRow(ROWS[v]);
      colAccess(ROWS[v], COLS[v], DATS[v], WRS[v], "R1 R2 R3 flat address");
      endRow();
    end

    // R8: row held across two column accesses
    startRow(8'h5A);
    colAccess(8'h5A, 8'h11, 8'h99, 1'b0, "R8 row kept first column");
    colAccess(8'h5A, 8'h2E, 8'h77, 1'b1, "R8 row kept second column");
    endRow();

    // R8: a new row fall replaces it
    startRow(8'hC3);
    colAccess(8'hC3, 8'h05, 8'h42, 1'b0, "R2 new row captured");
    endRow();

    // R6: write strobe without column access has no effect
    @(negedge clk);
    busAd = 8'hFF;
    rwN   = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 lone rwN no write", 32'(memWeN), 32'd1);
    chk("R6 lone rwN no select", 32'(memCsN), 32'd1);
    chk("R3 address unchanged without strobes", 32'(memAddr), 32'({6'h05, 8'hC3}));
    rwN = 1'b1;
    @(negedge clk);

    // R7: strobes fall together, pulse still two periods
    startRow(8'h10);
    @(negedge clk);
    busAd = rev8(8'h08);
    casN  = 1'b0;
    rwN   = 1'b0;
    @(negedge clk);
    chk("R7 joint fall pulse first", 32'(memWeN), 32'd0);
    chk("R9 bus routed to memory", 32'(memWrData), 32'h08);
    @(negedge clk);
    chk("R7 joint fall pulse second", 32'(memWeN), 32'd0);
    repeat (3) @(negedge clk);
    chk("R7 long hold no retrigger", 32'(memWeN), 32'd1);
    casN = 1'b1;
    rwN  = 1'b1;
    endRow();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule